// File: doc/BRIEF.md
# Power-On Strap Capture and Shared-Pin Function Controller

This block sits inside a clock generator. Several of its pins do double duty. While power-on reset is held, their output drivers stay off so that board-level pull resistors set the pin levels. The block samples those levels as configuration straps: a two-bit output-current multiplier, two frequency-select bits and a mode bit. Once reset is released, the straps are frozen. The drivers are then re-enabled so the pins can carry free-running PCI and reference clocks again.

The frozen mode bit sets the role of two shared pins. When mode is high, both pins drive a memory reference clock at half the CPU clock rate, one true and one inverted. When mode is low, both pins become active-low stop inputs. One stop input gates the CPU clock pair enable and the other gates the seven stoppable PCI clock enables. A stop request first passes through a synchronizer. It then reaches an enable only while the affected clock is in its low phase, so no shortened pulse can appear. The free-running PCI outputs never respond to a stop request.

Top module: `strap_pin_ctrl`

## Requirements
- R1: Strap pin levels are sampled on every clock edge while the internal reset is active. After release, `mult_code`, `fs_code` and `mode_mref` keep their values whatever the strap pins do later.
- R2: `iref_mult` gives the current multiplier that the latched code selects: code 0 gives 4, code 1 gives 5, code 2 gives 6 and code 3 gives 7 (multiple of IREF). `strap_oe` bit order is {mode, fs[1:0], mult[1:0]}.
- R3: `strap_oe` is all zero while reset is held and for the first two rising edges after `rst_n` rises. It becomes all ones after the third rising edge: two edges release the synchronizer and one more edge sets the enable.
- R4: With mode latched high, both shared-pin enables are 1. `shr_a_o` starts at 0 after reset and toggles once for each rising edge of `cpu_ph`, visible after the clock edge that first samples `cpu_ph` high. `shr_b_o` is always its complement.
- R5: With mode latched low, both shared-pin output enables stay 0.
- R6: With mode low, a low level on `shr_a_i` forces `cpu_en` to 0. A high level lets it return to 1. A change on the pin reaches `cpu_en` on the third rising edge, counting two synchronizer stages, and only on an edge where `cpu_ph` is sampled low. While `cpu_ph` is high, `cpu_en` holds its value.
- R7: With mode low, `shr_b_i` controls all `NUM_PCI` bits of `pci_en` in the same way, timed by `pci_ph`. `pci_free_en` stays 1 regardless of `shr_b_i`.
- R8: With mode high, the levels on `shr_a_i` and `shr_b_i` are ignored: `cpu_en` and `pci_en` stay all ones.
- R9: While `strap_oe` is zero, `cpu_en`, `pci_en` and `pci_free_en` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| strap_mult_pin | input | 2 | Level on the current-multiplier strap pins |
| strap_fs_pin | input | 2 | Level on the frequency-select strap pins |
| strap_mode_pin | input | 1 | Level on the mode strap pin |
| shr_a_i | input | 1 | Level on shared pin A (CPU stop, active low) |
| shr_b_i | input | 1 | Level on shared pin B (PCI stop, active low) |
| cpu_ph | input | 1 | Current level of the CPU clock |
| pci_ph | input | 1 | Current level of the PCI clock |
| strap_oe | output | 5 | Output enables of the strap pins {mode, fs, mult} |
| mult_code | output | 2 | Latched current-multiplier code |
| iref_mult | output | 3 | Current multiplier (4 to 7) |
| fs_code | output | 2 | Latched frequency-select bits |
| mode_mref | output | 1 | Latched mode: 1 = reference clock outputs, 0 = stop inputs |
| shr_a_o | output | 1 | Shared pin A drive value (half-rate reference) |
| shr_a_oe | output | 1 | Shared pin A output enable |
| shr_b_o | output | 1 | Shared pin B drive value (inverted reference) |
| shr_b_oe | output | 1 | Shared pin B output enable |
| cpu_en | output | 1 | Enable for both CPU clock pairs |
| pci_en | output | NUM_PCI | Enables for the stoppable PCI outputs |
| pci_free_en | output | 1 | Enable for the free-running PCI outputs |

## Verification
The bench walks all 32 strap combinations through a full reset cycle. It then flips every strap pin after release. A latch that kept sampling would follow the new levels, and a wrong multiplier decode would show in `iref_mult`. It counts edges across reset release, which exposes an enable that turns on too early or too late. In stop mode it changes the stop pins while the clock is high and lowers the clock only later: a design that skipped phase gating would cut a pulse short, and a missing synchronizer stage would show up as an enable change one edge early. In reference mode it drives the stop pins low and steps the CPU clock, catching a design that still obeys the stop pins or that toggles at the wrong rate.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef struct packed {
    logic       mode;
    logic [1:0] fs;
    logic [1:0] mult;
  } strap_t;

  localparam int STRAP_W = $bits(strap_t);

  localparam logic [2:0] IREF_BASE = 3'd4;

endpackage

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int W          = 5,
  parameter int RST_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  output logic [W-1:0] straps,
  output logic         live,
  output logic         oe
);

  logic [RST_STAGES-1:0] rsync_q, rsync_d;
  logic [W-1:0]          strap_q, strap_d;
  logic                  oe_q, oe_d;

  always_comb begin
    rsync_d = {rsync_q[RST_STAGES-2:0], 1'b1};
    strap_d = live ? strap_q : pins;
    oe_d    = live;
  end

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
      oe_q    <= 1'b0;
    end else begin
      rsync_q <= rsync_d;
      oe_q    <= oe_d;
    end
  end

  // The strap register has no reset: it samples during reset and then holds.
  always_ff @(posedge clk) begin
    strap_q <= strap_d;
  end

  assign live   = rsync_q[RST_STAGES-1];
  assign straps = strap_q;
  assign oe     = oe_q;

endmodule

// File: rtl/mref_gen.sv
module mref_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic cpu_ph,
  output logic mref
);

  logic ph_q, mref_q, mref_d;
  logic rise;

  always_comb begin
    rise   = cpu_ph & ~ph_q;
    mref_d = (run && rise) ? ~mref_q : mref_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= 1'b0;
      mref_q <= 1'b0;
    end else begin
      ph_q   <= cpu_ph;
      mref_q <= mref_d;
    end
  end

  assign mref = mref_q;

endmodule

// File: rtl/stop_gate.sv
module stop_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic live,
  input  logic use_stop,
  input  logic stop_pin_n,
  input  logic ph,
  output logic en
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   lvl;
  logic                   en_q, en_d;

  always_comb begin
    lvl    = use_stop ? stop_pin_n : 1'b1;
    sync_d = {sync_q[SYNC_STAGES-2:0], lvl};
    if (!live)
      en_d = 1'b0;
    else if (!ph)
      en_d = sync_q[SYNC_STAGES-1];
    else
      en_d = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      en_q   <= 1'b0;
    end else begin
      sync_q <= sync_d;
      en_q   <= en_d;
    end
  end

  assign en = en_q;

endmodule

// File: rtl/strap_pin_ctrl.sv
module strap_pin_ctrl
  import strap_pkg::*;
#(
  parameter int NUM_PCI     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         strap_mult_pin,
  input  logic [1:0]         strap_fs_pin,
  input  logic               strap_mode_pin,
  input  logic               shr_a_i,
  input  logic               shr_b_i,
  input  logic               cpu_ph,
  input  logic               pci_ph,
  output logic [4:0]         strap_oe,
  output logic [1:0]         mult_code,
  output logic [2:0]         iref_mult,
  output logic [1:0]         fs_code,
  output logic               mode_mref,
  output logic               shr_a_o,
  output logic               shr_a_oe,
  output logic               shr_b_o,
  output logic               shr_b_oe,
  output logic               cpu_en,
  output logic [NUM_PCI-1:0] pci_en,
  output logic               pci_free_en
);

  strap_t pin_v, strap_v;
  logic   live, oe, mref, pci_gate;

  assign pin_v = '{mode: strap_mode_pin, fs: strap_fs_pin, mult: strap_mult_pin};

  strap_latch #(.W(STRAP_W), .RST_STAGES(2)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins   (pin_v),
    .straps (strap_v),
    .live   (live),
    .oe     (oe)
  );

  mref_gen u_mref (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (live & strap_v.mode),
    .cpu_ph (cpu_ph),
    .mref   (mref)
  );

  stop_gate #(.SYNC_STAGES(SYNC_STAGES)) u_cpu_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .live       (live),
    .use_stop   (~strap_v.mode),
    .stop_pin_n (shr_a_i),
    .ph         (cpu_ph),
    .en         (cpu_en)
  );

  stop_gate #(.SYNC_STAGES(SYNC_STAGES)) u_pci_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .live       (live),
    .use_stop   (~strap_v.mode),
    .stop_pin_n (shr_b_i),
    .ph         (pci_ph),
    .en         (pci_gate)
  );

  for (genvar g = 0; g < NUM_PCI; g++) begin : g_pci
    assign pci_en[g] = pci_gate;
  end

  assign strap_oe    = {STRAP_W{oe}};
  assign mult_code   = strap_v.mult;
  assign iref_mult   = IREF_BASE + {1'b0, strap_v.mult};
  assign fs_code     = strap_v.fs;
  assign mode_mref   = strap_v.mode;
  assign shr_a_oe    = oe & strap_v.mode;
  assign shr_b_oe    = oe & strap_v.mode;
  assign shr_a_o     = mref;
  assign shr_b_o     = ~mref;
  assign pci_free_en = oe;

endmodule

// File: rtl/strap_pin_ctrl_chk.sv
module strap_pin_ctrl_chk #(
  parameter int NUM_PCI = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic [4:0]         strap_oe,
  input logic [1:0]         mult_code,
  input logic [1:0]         fs_code,
  input logic               mode_mref,
  input logic               cpu_ph,
  input logic               pci_ph,
  input logic               shr_a_o,
  input logic               shr_a_oe,
  input logic               cpu_en,
  input logic [NUM_PCI-1:0] pci_en
);

  p_strap_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strap_oe[0] |=> ($stable(mult_code) && $stable(fs_code) && $stable(mode_mref)));

  p_mref_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shr_a_oe && $rose(cpu_ph)) |=> (shr_a_o != $past(shr_a_o)));

  p_oe_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shr_a_oe |-> mode_mref);

  p_cpu_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ph |=> $stable(cpu_en));

  p_pci_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pci_ph |=> $stable(pci_en));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_oe[0] |-> (!cpu_en && (pci_en == '0)));

endmodule

bind strap_pin_ctrl strap_pin_ctrl_chk #(.NUM_PCI(NUM_PCI)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .strap_oe  (strap_oe),
  .mult_code (mult_code),
  .fs_code   (fs_code),
  .mode_mref (mode_mref),
  .cpu_ph    (cpu_ph),
  .pci_ph    (pci_ph),
  .shr_a_o   (shr_a_o),
  .shr_a_oe  (shr_a_oe),
  .cpu_en    (cpu_en),
  .pci_en    (pci_en)
);

// File: tb/strap_pin_ctrl_tb.sv
module strap_pin_ctrl_tb;

  localparam int NP = 7;
  localparam logic [NP-1:0] ALL = '1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    strap_mult_pin, strap_fs_pin;
  logic          strap_mode_pin;
  logic          shr_a_i, shr_b_i, cpu_ph, pci_ph;
  logic [4:0]    strap_oe;
  logic [1:0]    mult_code, fs_code;
  logic [2:0]    iref_mult;
  logic          mode_mref, shr_a_o, shr_a_oe, shr_b_o, shr_b_oe;
  logic          cpu_en, pci_free_en;
  logic [NP-1:0] pci_en;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  strap_pin_ctrl #(.NUM_PCI(NP), .SYNC_STAGES(2)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic run_combo(input logic [4:0] c);
    logic exp_m;
    rst_n = 1'b0;
    {strap_mode_pin, strap_fs_pin, strap_mult_pin} = c;
    shr_a_i = 1'b1; shr_b_i = 1'b1; cpu_ph = 1'b0; pci_ph = 1'b0;
    tick(3);
    chk("R3 oe in reset", strap_oe, 0);
    chk("R9 enables in reset", {cpu_en, pci_en, pci_free_en}, 0);
    rst_n = 1'b1;
    tick(2);
    chk("R3 oe two edges after release", strap_oe, 0);
    tick(1);
    chk("R3 oe third edge", strap_oe, 5'h1f);
    chk("R7 free-running on", pci_free_en, 1);
    {strap_mode_pin, strap_fs_pin, strap_mult_pin} = ~c;
    tick(3);
    chk("R1 mult held", mult_code, c[1:0]);
    chk("R1 fs held", fs_code, c[3:2]);
    chk("R1 mode held", mode_mref, c[4]);
    chk("R2 iref multiplier", iref_mult, 32'(c[1:0]) + 4);
    if (c[4]) begin
      chk("R4 shared oe", {shr_a_oe, shr_b_oe}, 2'b11);
      shr_a_i = 1'b0; shr_b_i = 1'b0;
      tick(4);
      chk("R8 cpu_en ignores pin", cpu_en, 1);
      chk("R8 pci_en ignores pin", pci_en, ALL);
      exp_m = 1'b0;
      for (int k = 0; k < 3; k++) begin
        chk("R4 mref level", {shr_a_o, shr_b_o}, {exp_m, ~exp_m});
        cpu_ph = 1'b1;
        tick(1);
        exp_m = ~exp_m;
        chk("R4 mref toggled", {shr_a_o, shr_b_o}, {exp_m, ~exp_m});
        cpu_ph = 1'b0;
        tick(2);
        chk("R4 mref steady low phase", shr_a_o, exp_m);
      end
    end else begin
      chk("R5 shared oe off", {shr_a_oe, shr_b_oe}, 2'b00);
      chk("R6 cpu_en running", cpu_en, 1);
      chk("R7 pci_en running", pci_en, ALL);
      cpu_ph = 1'b1; pci_ph = 1'b1;
      shr_a_i = 1'b0;
      tick(6);
      chk("R6 no change in high phase", cpu_en, 1);
      cpu_ph = 1'b0;
      tick(1);
      chk("R6 stopped at low phase", cpu_en, 0);
      shr_a_i = 1'b1;
      tick(2);
      chk("R6 sync latency", cpu_en, 0);
      tick(1);
      chk("R6 restart third edge", cpu_en, 1);
      shr_b_i = 1'b0;
      tick(6);
      chk("R7 no change in high phase", pci_en, ALL);
      pci_ph = 1'b0;
      tick(1);
      chk("R7 pci stopped", pci_en, 0);
      chk("R7 free-running unaffected", pci_free_en, 1);
      chk("R6 cpu unaffected by pci stop", cpu_en, 1);
      shr_b_i = 1'b1;
      tick(3);
      chk("R7 pci restart", pci_en, ALL);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    strap_mult_pin = '0; strap_fs_pin = '0; strap_mode_pin = 1'b0;
    shr_a_i = 1'b1; shr_b_i = 1'b1; cpu_ph = 1'b0; pci_ph = 1'b0;
    @(negedge clk);
    for (int c = 0; c < 32; c++) run_combo(5'(c));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule